// File: doc/BRIEF.md
# Scaled Pseudonoise Dither Injector

This block adds a small, programmable amount of pseudonoise to a complex (I/Q) sample stream. It is placed after a quadrature mixer. Each valid sample advances a maximal-length shift-register sequence by one step. The current sequence bit is treated as a sign and applied to a 16-bit gain, and the resulting signed dither word is added to the sample. The three sign bits of the dither word line up with the top three bits of the sample, so the dither never exceeds a quarter of full scale. A gain of zero, or a cleared enable, leaves the samples untouched.

The Q path draws its bits from the same sequence as the I path, but 1024 steps ahead, so the two dither streams are decorrelated. A mode input selects a short (2^15−1) or long (2^23−1) sequence. The sum is clamped at the sample range rather than wrapping. Typical uses are wideband test stimulus for checking filter responses and a deliberate reduction of receiver sensitivity.

Top module: `pn_dither_injector`

## Requirements
- R1: During and directly after reset, out_valid is 0 and out_i and out_q are 0.
- R2: out_valid equals in_valid delayed by one clock. out_i and out_q change only in the cycle after a valid input and hold their value otherwise.
- R3: While pn_enable is 0, each output equals its input one cycle later, and both generators are parked at their start states. On re-enable, the sequence restarts from its first bit.
- R4: With pn_gain equal to 0, each output equals its input one cycle later, whatever the sequence bits are.
- R5: The dither word is +pn_gain when the sequence bit is 0 and −pn_gain when it is 1. It is formed as a 19-bit two's-complement value and shifted left by DATA_W−19, so its magnitude stays below one quarter of full scale.
- R6: With long_mode = 0, the generator implements x^15+x^14+1. The 15-bit state starts at 1. The bit used for a sample is state bit 14, taken before the step. A step shifts the state left and inserts bit14 XOR bit13 at bit 0.
- R7: With long_mode = 1, the generator implements x^23+x^18+1. The 23-bit state starts at 1. The bit used is state bit 22, taken before the step. A step inserts bit22 XOR bit17 at bit 0.
- R8: The Q sequence bit for the n-th valid sample since enable equals the I sequence bit for sample n+1024.
- R9: The generators advance exactly once per valid input sample while enabled and hold on cycles without a valid input.
- R10: A sum beyond the signed DATA_W range is clamped to the most positive or most negative value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pn_enable | input | 1 | Dither enable; 0 parks the generators and passes samples through |
| long_mode | input | 1 | 0: 2^15−1 sequence, 1: 2^23−1 sequence |
| pn_gain | input | 16 | Dither magnitude |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | DATA_W | In-phase sample, two's complement |
| in_q | input | DATA_W | Quadrature sample, two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | DATA_W | Dithered in-phase sample |
| out_q | output | DATA_W | Dithered quadrature sample |

## Verification
The checker assumes that long_mode changes only while pn_enable is 0. A mode change with the generators running would leave them in a state from the other polynomial. The bench therefore switches mode only inside a disabled window before each stream. The bounded-deviation property assumes DATA_W is at least 19, so that the shift is non-negative; the bench uses 24. Stimulus includes sample values near both rails, so the clamp is reached from above and below.

// File: rtl/pn_dither_injector.sv
module pn_dither_injector #(
  parameter int DATA_W = 24,
  parameter int GAIN_W = 16,
  parameter int Q_LAG  = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pn_enable,
  input  logic              long_mode,
  input  logic [GAIN_W-1:0] pn_gain,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_i,
  input  logic [DATA_W-1:0] in_q,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_i,
  output logic [DATA_W-1:0] out_q
);
  localparam int PN_W  = GAIN_W + 3;
  localparam int SHIFT = DATA_W - PN_W;
  localparam logic [22:0] START = 23'd1;

  function automatic logic [22:0] lfsr_next(input logic [22:0] s, input logic lng);
    logic fb;
    fb = lng ? (s[22] ^ s[17]) : (s[14] ^ s[13]);
    return lng ? {s[21:0], fb} : {8'd0, s[13:0], fb};
  endfunction

  function automatic logic [22:0] lfsr_jump(input logic [22:0] s, input logic lng, input int n);
    logic [22:0] t;
    t = s;
    for (int k = 0; k < n; k++) t = lfsr_next(t, lng);
    return t;
  endfunction

  localparam logic [22:0] Q_START_S = lfsr_jump(START, 1'b0, Q_LAG);
  localparam logic [22:0] Q_START_L = lfsr_jump(START, 1'b1, Q_LAG);

  function automatic logic [DATA_W-1:0] sat_add(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    logic [DATA_W:0] s;
    s = {a[DATA_W-1], a} + {b[DATA_W-1], b};
    if (s[DATA_W] != s[DATA_W-1])
      return s[DATA_W] ? {1'b1, {(DATA_W-1){1'b0}}} : {1'b0, {(DATA_W-1){1'b1}}};
    return s[DATA_W-1:0];
  endfunction

  logic [22:0] i_st, q_st;
  logic        i_bit, q_bit;
  logic [PN_W-1:0]   mag, pn_i, pn_q;
  logic [DATA_W-1:0] add_i, add_q;

  assign i_bit = long_mode ? i_st[22] : i_st[14];
  assign q_bit = long_mode ? q_st[22] : q_st[14];

  assign mag  = {3'b000, pn_gain};
  assign pn_i = i_bit ? (~mag + PN_W'(1)) : mag;
  assign pn_q = q_bit ? (~mag + PN_W'(1)) : mag;

  assign add_i = pn_enable ? (DATA_W'($signed(pn_i)) << SHIFT) : '0;
  assign add_q = pn_enable ? (DATA_W'($signed(pn_q)) << SHIFT) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || !pn_enable) begin
      i_st <= START;
      q_st <= long_mode ? Q_START_L : Q_START_S;
    end else if (in_valid) begin
      i_st <= lfsr_next(i_st, long_mode);
      q_st <= lfsr_next(q_st, long_mode);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_i <= sat_add(in_i, add_i);
        out_q <= sat_add(in_q, add_q);
      end
    end
  end
endmodule

module pn_dither_injector_chk #(
  parameter int DATA_W = 24,
  parameter int GAIN_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pn_enable,
  input logic [GAIN_W-1:0] pn_gain,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_i,
  input logic [DATA_W-1:0] in_q,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_i,
  input logic [DATA_W-1:0] out_q,
  input logic [22:0]       i_st,
  input logic [22:0]       q_st
);
  localparam int SHIFT = DATA_W - GAIN_W - 3;

  logic              was_on;
  logic [DATA_W-1:0] prev_i;
  logic [DATA_W+1:0] lim;
  logic signed [DATA_W+1:0] d_i;

  always_ff @(posedge clk) begin
    was_on <= rst_n && in_valid && pn_enable;
    prev_i <= in_i;
    lim    <= (DATA_W+2)'(pn_gain) << SHIFT;
  end

  assign d_i = $signed((DATA_W+2)'($signed(out_i))) - $signed((DATA_W+2)'($signed(prev_i)));

  a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !out_valid && out_i == '0 && out_q == '0);
  a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid);
  a_r2_hold_idle:   assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid && $stable(out_i) && $stable(out_q));
  a_r3_bypass:      assert property (@(posedge clk) disable iff (!rst_n) in_valid && !pn_enable |=> out_i == $past(in_i) && out_q == $past(in_q));
  a_r4_zero_gain:   assert property (@(posedge clk) disable iff (!rst_n) in_valid && pn_gain == '0 |=> out_i == $past(in_i) && out_q == $past(in_q));
  a_r9_hold_state:  assert property (@(posedge clk) disable iff (!rst_n) pn_enable && !in_valid |=> $stable(i_st) && $stable(q_st));
  a_r9_step_state:  assert property (@(posedge clk) disable iff (!rst_n) pn_enable && in_valid |=> i_st != $past(i_st));
  a_r5_bounded:     assert property (@(posedge clk) disable iff (!rst_n) was_on |-> (d_i <= $signed(lim)) && (d_i >= -$signed(lim)));
endmodule

bind pn_dither_injector pn_dither_injector_chk #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pn_enable(pn_enable), .pn_gain(pn_gain),
  .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
  .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
  .i_st(i_st), .q_st(q_st)
);

// File: tb/tb_pn_dither_injector.sv
module tb_pn_dither_injector;
  localparam int DW = 24;
  localparam int SH = DW - 19;
  localparam int LAG = 1024;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pn_enable = 1'b0;
  logic          long_mode = 1'b0;
  logic [15:0]   pn_gain = '0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_i = '0, in_q = '0;
  logic          out_valid;
  logic [DW-1:0] out_i, out_q;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [22:0] mi, mq;
  int sat_hits = 0;

  always #4 clk = ~clk;

  pn_dither_injector #(.DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .pn_enable(pn_enable), .long_mode(long_mode),
    .pn_gain(pn_gain), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q));

  function automatic logic [22:0] m_next(logic [22:0] s, logic lng);
    if (lng) return {s[21:0], s[22] ^ s[17]};
    return {8'd0, s[13:0], s[14] ^ s[13]};
  endfunction

  function automatic logic m_bit(logic [22:0] s, logic lng);
    return lng ? s[22] : s[14];
  endfunction

  function automatic logic [DW-1:0] m_out(logic [DW-1:0] x, logic b, logic [15:0] g, logic en);
    longint v, d;
    d = en ? longint'(g) * (longint'(1) << SH) : 0;
    v = longint'($signed(x)) + (b ? -d : d);
    if (v > (longint'(1) << (DW-1)) - 1) v = (longint'(1) << (DW-1)) - 1;
    if (v < -(longint'(1) << (DW-1))) v = -(longint'(1) << (DW-1));
    return DW'(v);
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_restart();
    mi = 23'd1;
    mq = 23'd1;
    for (int k = 0; k < LAG; k++) mq = m_next(mq, long_mode);
  endtask

  task automatic set_mode(logic lng, logic [15:0] g);
    @(negedge clk);
    in_valid = 1'b0; pn_enable = 1'b0; long_mode = lng; pn_gain = g;
    @(negedge clk);
    pn_enable = 1'b1;
    model_restart();
  endtask

  task automatic step(string req, logic v, logic [DW-1:0] xi, logic [DW-1:0] xq);
    logic [DW-1:0] ei, eq, hi, hq;
    hi = out_i; hq = out_q;
    in_valid = v; in_i = xi; in_q = xq;
    if (v) begin
      ei = m_out(xi, m_bit(mi, long_mode), pn_gain, pn_enable);
      eq = m_out(xq, m_bit(mq, long_mode), pn_gain, pn_enable);
      if (pn_enable) begin mi = m_next(mi, long_mode); mq = m_next(mq, long_mode); end
    end else begin
      ei = hi; eq = hq;
    end
    @(posedge clk); #1;
    check({req, " valid"}, {{(DW-1){1'b0}}, out_valid}, {{(DW-1){1'b0}}, v});
    check({req, " I"}, out_i, ei);
    check({req, " Q"}, out_q, eq);
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 valid", {{(DW-1){1'b0}}, out_valid}, '0);
    check("R1 I", out_i, '0);
    check("R1 Q", out_q, '0);
  endtask

  task automatic t_bypass();
    @(negedge clk);
    pn_enable = 1'b0; pn_gain = 16'hFFFF;
    for (int k = 0; k < 40; k++) step("R3 bypass", 1'b1, DW'(k * 104729), DW'(-k * 7919));
  endtask

  task automatic t_zero_gain();
    set_mode(1'b1, 16'h0000);
    for (int k = 0; k < 60; k++) step("R4 zero gain", 1'b1, DW'(k * 31337), DW'(k * 271));
  endtask

  task automatic t_stream(string req, logic lng, logic [15:0] g, int n);
    set_mode(lng, g);
    for (int k = 0; k < n; k++) step(req, 1'b1, DW'(k * 40503 + 12345), DW'(k * 65599 - 777));
  endtask

  task automatic t_gaps();
    set_mode(1'b0, 16'h1234);
    for (int k = 0; k < 300; k++) step("R9 gaps", (k % 3) != 1, DW'(k * 999), DW'(k * 4421));
    pn_enable = 1'b0;
    step("R3 park", 1'b0, '0, '0);
    pn_enable = 1'b1;
    model_restart();
    for (int k = 0; k < 100; k++) step("R3 restart", 1'b1, DW'(k), DW'(-k));
  endtask

  task automatic t_saturate();
    logic [DW-1:0] mx, mn;
    mx = {1'b0, {(DW-1){1'b1}}};
    mn = {1'b1, {(DW-1){1'b0}}};
    set_mode(1'b1, 16'hFFFF);
    for (int k = 0; k < 200; k++) begin
      step("R10 clamp", 1'b1, (k % 2 == 0) ? mx : mn, (k % 2 == 0) ? mn : mx);
      if (out_i == mx || out_i == mn) sat_hits++;
    end
    checks++;
    if (sat_hits == 0) begin
      fails++;
      $display("FAIL R10: actual %0d clamped outputs expected more than 0", sat_hits);
    end
  endtask

  task automatic t_lag();
    bit ib [0:LAG+99];
    bit qb [0:99];
    set_mode(1'b0, 16'h0001);
    for (int k = 0; k < LAG + 100; k++) begin
      in_valid = 1'b1; in_i = '0; in_q = '0;
      @(posedge clk); #1;
      ib[k] = out_i[DW-1];
      if (k < 100) qb[k] = out_q[DW-1];
      @(negedge clk);
    end
    in_valid = 1'b0;
    for (int k = 0; k < 100; k++)
      check("R8 lag", {{(DW-1){1'b0}}, qb[k]}, {{(DW-1){1'b0}}, ib[k + LAG]});
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_bypass();
    t_zero_gain();
    t_stream("R6 R5 short", 1'b0, 16'h8001, 2000);
    t_stream("R7 R5 long", 1'b1, 16'h7FFF, 2000);
    t_stream("R8 R7 small", 1'b1, 16'h0003, 1500);
    t_gaps();
    t_saturate();
    t_lag();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule